// File: doc/BRIEF.md
# Static Memory Strobe Sequencer

This block turns a single access request into the control waveforms of an asynchronous static memory bus. It supplies an address, a chip-select line for each device, a read strobe, a write strobe and byte selects, and raises a one-cycle completion pulse. Each chip select has its own timing set for reads and for writes, counted in master clock cycles. For both the data strobe and the chip-select line, that set gives a setup delay and a pulse width. It also gives the total length of the access.

A power-management source can assert a slow-clock input when the master clock drops to a very low rate, for example around 32 kHz. While that input is high, every access on every chip select uses one fixed, minimal waveform set instead of the programmed values. Software therefore never has to rewrite the timing sets when the clock slows down. The mode input is sampled only when an access is accepted, so an access already under way keeps its waveform.

Top module: `smem_strobe_gen`

## Requirements
- R1: After reset and whenever no access is in progress, every chip-select line, the read strobe, the write strobe and every byte select sit high (all active low), and `done` is low.
- R2: An access starts with an internal count of 0 and adds one each cycle. A strobe (read or write data strobe, or the chip-select line) is low in exactly those cycles whose count is at least its setup value and below its setup plus pulse.
- R3: An access lasts as many cycles as its programmed span (a span of 0 counts as 1). `done` is high only in the final cycle of the access.
- R4: In slow-clock mode a read lasts 2 cycles. The chip-select line is low in both cycles, the read strobe is low only in the second cycle, and the write strobe stays high.
- R5: In slow-clock mode a write lasts 3 cycles. The chip-select line is low in all three cycles, the write strobe is low only in the second cycle, and the read strobe stays high.
- R6: The slow-clock waveforms apply to every chip select, whatever timing values are programmed for it.
- R7: The slow-clock input is sampled only in the cycle an access is accepted. A change during an access does not alter that access.
- R8: Address, chip-select choice and byte selects (`mem_be_n` = inverted `req_be`) hold constant for every cycle of an access.
- R9: A request is accepted when `req` is high at a clock edge while idle, and that access's first cycle follows the edge. Requests made during an access are ignored. After the `done` cycle there is one idle cycle before the next access.
- R10: Read and write strobes are never low together. Only the line `mem_cs_n[k]`, where k is the `req_cs` index latched at acceptance, can go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_mode | input | 1 | Slow-clock override from power management |
| req | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Chip-select index |
| req_addr | input | ADDR_W | Access address |
| req_be | input | BE_W | Byte enables, active high |
| rd_stb_setup | input | NUM_CS*TIM_W | Read strobe setup per chip select |
| rd_stb_pulse | input | NUM_CS*TIM_W | Read strobe pulse per chip select |
| rd_sel_setup | input | NUM_CS*TIM_W | Chip-select setup on reads |
| rd_sel_pulse | input | NUM_CS*TIM_W | Chip-select pulse on reads |
| rd_span | input | NUM_CS*TIM_W | Read access length |
| wr_stb_setup | input | NUM_CS*TIM_W | Write strobe setup per chip select |
| wr_stb_pulse | input | NUM_CS*TIM_W | Write strobe pulse per chip select |
| wr_sel_setup | input | NUM_CS*TIM_W | Chip-select setup on writes |
| wr_sel_pulse | input | NUM_CS*TIM_W | Chip-select pulse on writes |
| wr_span | input | NUM_CS*TIM_W | Write access length |
| mem_addr | output | ADDR_W | Bus address |
| mem_cs_n | output | NUM_CS | Chip-select lines, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_be_n | output | BE_W | Byte selects, active low |
| done | output | 1 | High in the final cycle of an access |

## Verification
The assertions check on every cycle that the bus is quiet when idle and that the two data strobes never overlap. They also check that at most one chip-select line is low, that address and byte selects hold through an access, and that `done` is followed by an idle cycle. Two further assertions fix the exact slow-clock read and write waveforms from the moment of acceptance. Only the bench's scenarios can show the programmed per-chip-select timings and the degenerate zero span. They also cover the slow-clock input changing mid-access, requests ignored while busy, and the spacing of back-to-back accesses.

// File: rtl/smem_pkg.sv
`timescale 1ns/1ps
package smem_pkg;
    localparam int TIM_W = 6;

    typedef logic [TIM_W-1:0] tcnt_t;

    // Timing set for one access: data strobe, chip-select line, total span
    typedef struct packed {
        tcnt_t stb_setup;
        tcnt_t stb_pulse;
        tcnt_t sel_setup;
        tcnt_t sel_pulse;
        tcnt_t span;
    } tmg_t;

    function automatic tmg_t mk_tmg(int ss, int sp, int cs, int cp, int sn);
        tmg_t t;
        t.stb_setup = tcnt_t'(ss);
        t.stb_pulse = tcnt_t'(sp);
        t.sel_setup = tcnt_t'(cs);
        t.sel_pulse = tcnt_t'(cp);
        t.span      = tcnt_t'(sn);
        return t;
    endfunction

    // Fixed minimal waveforms used while the master clock runs slow
    localparam tmg_t SLOW_RD = mk_tmg(1, 1, 0, 2, 2);
    localparam tmg_t SLOW_WR = mk_tmg(1, 1, 0, 3, 3);
endpackage

// File: rtl/smem_win.sv
`timescale 1ns/1ps
module smem_win #(
    parameter int W = 6
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] setup,
    input  logic [W-1:0] pulse,
    output logic         on
);
    logic [W:0] stop;

    assign stop = {1'b0, setup} + {1'b0, pulse};
    assign on   = (cnt >= setup) && ({1'b0, cnt} < stop);
endmodule

// File: rtl/smem_tmg_sel.sv
`timescale 1ns/1ps
module smem_tmg_sel
    import smem_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2,
    localparam int VW    = NUM_CS * TIM_W
) (
    input  logic            slow,
    input  logic            wr,
    input  logic [CS_W-1:0] cs,
    input  logic [VW-1:0]   rd_stb_setup,
    input  logic [VW-1:0]   rd_stb_pulse,
    input  logic [VW-1:0]   rd_sel_setup,
    input  logic [VW-1:0]   rd_sel_pulse,
    input  logic [VW-1:0]   rd_span,
    input  logic [VW-1:0]   wr_stb_setup,
    input  logic [VW-1:0]   wr_stb_pulse,
    input  logic [VW-1:0]   wr_sel_setup,
    input  logic [VW-1:0]   wr_sel_pulse,
    input  logic [VW-1:0]   wr_span,
    output tmg_t            tmg
);
    tmg_t rd_tab [NUM_CS];
    tmg_t wr_tab [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_tab
        assign rd_tab[i] = '{stb_setup: rd_stb_setup[i*TIM_W +: TIM_W],
                             stb_pulse: rd_stb_pulse[i*TIM_W +: TIM_W],
                             sel_setup: rd_sel_setup[i*TIM_W +: TIM_W],
                             sel_pulse: rd_sel_pulse[i*TIM_W +: TIM_W],
                             span:      rd_span[i*TIM_W +: TIM_W]};
        assign wr_tab[i] = '{stb_setup: wr_stb_setup[i*TIM_W +: TIM_W],
                             stb_pulse: wr_stb_pulse[i*TIM_W +: TIM_W],
                             sel_setup: wr_sel_setup[i*TIM_W +: TIM_W],
                             sel_pulse: wr_sel_pulse[i*TIM_W +: TIM_W],
                             span:      wr_span[i*TIM_W +: TIM_W]};
    end

    always_comb begin
        if (slow) begin
            tmg = wr ? SLOW_WR : SLOW_RD;
        end else begin
            tmg = wr ? wr_tab[cs] : rd_tab[cs];
        end
    end
endmodule

// File: rtl/smem_strobe_gen.sv
`timescale 1ns/1ps
module smem_strobe_gen
    import smem_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int ADDR_W  = 24,
    parameter int BE_W    = 4,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int VW     = NUM_CS * TIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_mode,
    input  logic              req,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [VW-1:0]     rd_stb_setup,
    input  logic [VW-1:0]     rd_stb_pulse,
    input  logic [VW-1:0]     rd_sel_setup,
    input  logic [VW-1:0]     rd_sel_pulse,
    input  logic [VW-1:0]     rd_span,
    input  logic [VW-1:0]     wr_stb_setup,
    input  logic [VW-1:0]     wr_stb_pulse,
    input  logic [VW-1:0]     wr_sel_setup,
    input  logic [VW-1:0]     wr_sel_pulse,
    input  logic [VW-1:0]     wr_span,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [BE_W-1:0]   mem_be_n,
    output logic              done
);
    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [CS_W-1:0]   cs;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        tcnt_t             cnt;
        tmg_t              tmg;
    } st_t;

    st_t   st_d, st_q;
    tmg_t  new_tmg;
    tcnt_t last_cnt;
    logic  last_cyc;
    logic  stb_on, sel_on;
    logic  busy_q;

    // Timing chosen at acceptance: slow set or the chip select's own set
    smem_tmg_sel #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_sel (
        .slow         (slow_mode),
        .wr           (req_write),
        .cs           (req_cs),
        .rd_stb_setup (rd_stb_setup),
        .rd_stb_pulse (rd_stb_pulse),
        .rd_sel_setup (rd_sel_setup),
        .rd_sel_pulse (rd_sel_pulse),
        .rd_span      (rd_span),
        .wr_stb_setup (wr_stb_setup),
        .wr_stb_pulse (wr_stb_pulse),
        .wr_sel_setup (wr_sel_setup),
        .wr_sel_pulse (wr_sel_pulse),
        .wr_span      (wr_span),
        .tmg          (new_tmg)
    );

    smem_win #(.W(TIM_W)) u_stb_win (
        .cnt   (st_q.cnt),
        .setup (st_q.tmg.stb_setup),
        .pulse (st_q.tmg.stb_pulse),
        .on    (stb_on)
    );

    smem_win #(.W(TIM_W)) u_sel_win (
        .cnt   (st_q.cnt),
        .setup (st_q.tmg.sel_setup),
        .pulse (st_q.tmg.sel_pulse),
        .on    (sel_on)
    );

    // A zero span is treated as a one-cycle access
    assign last_cnt = (st_q.tmg.span == '0) ? '0 : st_q.tmg.span - tcnt_t'(1);
    assign last_cyc = st_q.busy && (st_q.cnt == last_cnt);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req) begin
                st_d.busy = 1'b1;
                st_d.wr   = req_write;
                st_d.cs   = req_cs;
                st_d.addr = req_addr;
                st_d.be   = req_be;
                st_d.cnt  = '0;
                st_d.tmg  = new_tmg;
            end
        end else if (last_cyc) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + tcnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
        assign mem_cs_n[k] = ~(st_q.busy && sel_on && (st_q.cs == CS_W'(k)));
    end

    assign mem_addr = st_q.addr;
    assign mem_rd_n = ~(st_q.busy && !st_q.wr && stb_on);
    assign mem_wr_n = ~(st_q.busy && st_q.wr && stb_on);
    assign mem_be_n = st_q.busy ? ~st_q.be : '1;
    assign done     = last_cyc;
    assign busy_q   = st_q.busy;
endmodule

// File: rtl/smem_chk.sv
`timescale 1ns/1ps
module smem_chk #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              req,
    input logic              req_write,
    input logic              slow_mode,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [BE_W-1:0]   mem_be_n,
    input logic              done
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&mem_cs_n && mem_rd_n && mem_wr_n && &mem_be_n && !done));

    a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    a_r10_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    a_r9_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r4_slow_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && slow_mode && !req_write) |=>
            (!(&mem_cs_n) && mem_rd_n && mem_wr_n && !done)
            ##1 (!(&mem_cs_n) && !mem_rd_n && done));

    a_r5_slow_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && slow_mode && req_write) |=>
            (!(&mem_cs_n) && mem_wr_n && mem_rd_n && !done)
            ##1 (!(&mem_cs_n) && !mem_wr_n && !done)
            ##1 (!(&mem_cs_n) && mem_wr_n && done));
endmodule

bind smem_strobe_gen smem_chk #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W),
    .BE_W   (BE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_q),
    .req       (req),
    .req_write (req_write),
    .slow_mode (slow_mode),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_be_n  (mem_be_n),
    .done      (done)
);

// File: tb/sim_smem_strobe_gen.sv
`timescale 1ns/1ps
module sim_smem_strobe_gen;
    localparam int NCS = 4;
    localparam int AW  = 24;
    localparam int BW  = 4;
    localparam int TW  = 6;
    localparam int VW  = NCS * TW;

    // Vector fields: [15] slow, [14] write, [13:12] cs, [11:8] be, [7:0] address low byte
    localparam logic [15:0] VEC [8] = '{16'h0F11, 16'h1A22, 16'h6333, 16'h7C44,
                                        16'h8F55, 16'hB166, 16'hC577, 16'hE288};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_mode = 1'b0;
    logic req = 1'b0;
    logic req_write = 1'b0;
    logic [1:0] req_cs = '0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_be = '0;
    logic [VW-1:0] rd_stb_setup, rd_stb_pulse, rd_sel_setup, rd_sel_pulse, rd_span;
    logic [VW-1:0] wr_stb_setup, wr_stb_pulse, wr_sel_setup, wr_sel_pulse, wr_span;
    logic [AW-1:0] mem_addr;
    logic [NCS-1:0] mem_cs_n;
    logic mem_rd_n, mem_wr_n, done;
    logic [BW-1:0] mem_be_n;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    smem_strobe_gen #(.NUM_CS(NCS), .ADDR_W(AW), .BE_W(BW)) u0 (.*);

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [63:0] bus(input logic [NCS-1:0] c, input logic r, input logic w,
                                        input logic [BW-1:0] b, input logic d, input logic [AW-1:0] a);
        return 64'({c, r, w, b, d, a});
    endfunction

    function automatic logic [63:0] act_bus();
        return bus(mem_cs_n, mem_rd_n, mem_wr_n, mem_be_n, done, mem_addr);
    endfunction

    // One access checked cycle by cycle; expectations from the requirements
    task automatic run_access(input bit slow, input bit wr, input logic [1:0] cs,
                              input logic [AW-1:0] addr, input logic [BW-1:0] be,
                              input bit flip_slow, input bit poke);
        int ss, sp, cs_s, cs_p, cy;
        string tag;
        if (slow) begin
            ss = 1; sp = 1; cs_s = 0; cs_p = wr ? 3 : 2; cy = wr ? 3 : 2;
            tag = wr ? "R5/R6" : "R4/R6";
        end else if (!wr) begin
            ss = int'(cs); sp = 2; cs_s = int'(cs) % 2; cs_p = int'(cs) + 3; cy = int'(cs) + 4;
            tag = "R2/R3";
        end else begin
            ss = 1; sp = int'(cs) + 1; cs_s = 0; cs_p = int'(cs) + 3; cy = int'(cs) + 3;
            tag = "R2/R3";
        end
        if (flip_slow) tag = {tag, "/R7"};
        if (poke) tag = {tag, "/R8/R9"};
        @(negedge clk);
        slow_mode = slow; req = 1'b1; req_write = wr; req_cs = cs; req_addr = addr; req_be = be;
        @(negedge clk);
        req = 1'b0;
        if (flip_slow) slow_mode = ~slow;
        for (int k = 0; k < cy; k++) begin
            logic stb, sel;
            logic [NCS-1:0] ecs;
            stb = (k >= ss) && (k < ss + sp);
            sel = (k >= cs_s) && (k < cs_s + cs_p);
            ecs = sel ? ~(NCS'(1) << cs) : '1;
            chk(tag, act_bus(), bus(ecs, !(stb && !wr), !(stb && wr), ~be, k == cy - 1, addr));
            if (poke && k == 1) begin
                req = 1'b1; req_write = ~wr; req_addr = ~addr; req_be = ~be; req_cs = cs + 2'd1;
            end
            if (poke && k == 2) req = 1'b0;
            if (k < cy - 1) @(negedge clk);
        end
        @(negedge clk);
        chk("R1/R9 idle after done", act_bus(), bus('1, 1'b1, 1'b1, '1, 1'b0, addr));
    endtask

    initial begin
        for (int i = 0; i < NCS; i++) begin
            rd_stb_setup[i*TW +: TW] = TW'(i);
            rd_stb_pulse[i*TW +: TW] = TW'(2);
            rd_sel_setup[i*TW +: TW] = TW'(i % 2);
            rd_sel_pulse[i*TW +: TW] = TW'(i + 3);
            rd_span[i*TW +: TW]      = TW'(i + 4);
            wr_stb_setup[i*TW +: TW] = TW'(1);
            wr_stb_pulse[i*TW +: TW] = TW'(i + 1);
            wr_sel_setup[i*TW +: TW] = TW'(0);
            wr_sel_pulse[i*TW +: TW] = TW'(i + 3);
            wr_span[i*TW +: TW]      = TW'(i + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", act_bus(), bus('1, 1'b1, 1'b1, '1, 1'b0, '0));

        for (int i = 0; i < 8; i++) begin
            run_access(VEC[i][15], VEC[i][14], VEC[i][13:12], {16'hC0DE, VEC[i][7:0]},
                       VEC[i][11:8], 1'b0, 1'b0);
        end

        // R7: slow input changes mid-access in both directions
        run_access(1'b0, 1'b0, 2'd1, 24'h123456, 4'h9, 1'b1, 1'b0);
        run_access(1'b1, 1'b1, 2'd3, 24'h654321, 4'h6, 1'b1, 1'b0);
        // R8/R9: requests during an access are ignored
        run_access(1'b0, 1'b0, 2'd3, 24'hABCDEF, 4'h5, 1'b0, 1'b1);

        // R9: held request, slow read of 2 cycles: done pattern 0,1,0,0,1,0
        @(negedge clk);
        slow_mode = 1'b1; req = 1'b1; req_write = 1'b0; req_cs = 2'd2;
        req_addr = 24'h00BEEF; req_be = 4'hF;
        @(negedge clk);
        for (int n = 0; n < 6; n++) begin
            chk("R9 back-to-back done spacing", 64'(done), 64'((n == 1) || (n == 4)));
            if (n == 5) req = 1'b0;
            @(negedge clk);
        end
        slow_mode = 1'b0;

        // R3: zero span on chip select 3 writes gives a one-cycle access
        wr_span[3*TW +: TW] = '0;
        wr_stb_setup[3*TW +: TW] = '0;
        wr_stb_pulse[3*TW +: TW] = TW'(1);
        wr_sel_pulse[3*TW +: TW] = TW'(1);
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_cs = 2'd3; req_addr = 24'h0F0F0F; req_be = 4'h3;
        @(negedge clk);
        req = 1'b0;
        chk("R3 zero span single cycle", act_bus(), bus(4'b0111, 1'b1, 1'b0, 4'hC, 1'b1, 24'h0F0F0F));
        @(negedge clk);
        chk("R3 zero span then idle", act_bus(), bus('1, 1'b1, 1'b1, '1, 1'b0, 24'h0F0F0F));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule